// File: doc/BRIEF.md
# Retrigger-Locked One-Shot Pulse Timer

This block turns a single trigger into one delayed pulse on each of several output channels. Once software enables it and selects one-shot mode, the counter parks at its all-ones value and waits. A trigger can be a rising edge on an asynchronous input pin or a write of 1 to a strobe bit in the control register. When the trigger is taken, the counter restarts at zero and counts up at a rate set by a power-of-two prescaler. Each channel drives its output high from the count equal to its own compare value up to and including the count equal to a shared period value. After the period count has run its full length, the counter parks again at all-ones.

The compare values are copied into working buffers at the moment a trigger is taken, so software may reprogram them while a pulse is running without disturbing it. Triggers that arrive while a pulse is in progress are dropped. Single-cycle interrupt strobes mark the moment the counter reaches the period value and each channel's compare value.

Top module: `one_shot_timer`

## Requirements
- R1: After reset the counter output reads all-ones, every pulse and interrupt output is 0, and every register reads back as 0.
- R2: Register map: address 0 is control (bit 0 enable, bits 3:1 clock select, bits 6:4 mode, bit 7 software trigger), address 1 is the period compare, addresses 2 to 2+NCH-1 are the channel compares, and other addresses read as 0. Read data appears registered one cycle after the address is presented, and control bit 7 always reads 0.
- R3: Triggers are taken only while enable is 1 and mode is 3'b011. A control write with bit 7 set makes the counter read 0 one cycle after the write edge. While waiting, the counter reads all-ones.
- R4: A rising edge on the external trigger input passes a two-flop synchronizer and an edge detector, so the counter reads 0 after the third rising clock edge that samples the input high.
- R5: With clock select S each count value lasts 2^S clock cycles. Channel k goes high after its compare value times 2^S cycles from the count reaching 0 and stays high for (period − compare + 1) × 2^S cycles.
- R6: After the count equal to the period has lasted its full length, the counter returns to all-ones and all channels go low; a new trigger then starts another pulse.
- R7: A software or external trigger that arrives while a pulse is in progress is ignored and is not remembered.
- R8: Interrupt bit 0 is high for exactly one cycle when the count first equals the period value; interrupt bit k is high for exactly one cycle when the count first equals channel k's compare value.
- R9: Period and channel compare values are captured when a trigger is taken; writes during a pulse affect only the next pulse.
- R10: Clearing enable forces all channel outputs low and the counter to all-ones on the next cycle; no trigger is pending when enable is set again.
- R11: A channel whose compare value exceeds the period never goes high and never raises its interrupt.
- R12: With a mode other than 3'b011, triggers are ignored and the counter stays at all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address for writes and reads |
| reg_wdata | input | CW | Register write data |
| reg_rdata | output | CW | Registered read data |
| ext_trig | input | 1 | Asynchronous external trigger, rising edge active |
| pulse_out | output | NCH | Channel pulse outputs, active high |
| irq_out | output | NCH+1 | Interrupt strobes: bit 0 period match, bit k channel k match |
| count_out | output | CW | Current counter value |

## Verification
The bench builds the timer with an 8-bit counter and three channels, which keeps every pulse short enough to sweep the period over 0 to 7, one channel's compare over 0 to 8 and the clock select over 0 to 2. With the second channel tied to the period and the third set one above it, every sweep point covers the single-count pulse and the never-active channel as well, and each start, edge, width and interrupt position is compared against the arithmetic formulas. Directed runs add the external synchronizer latency, retriggering during a pulse from both sources, mid-pulse compare writes, disabling mid-pulse and a foreign mode value.

// File: rtl/ost_pkg.sv
package ost_pkg;
  localparam logic [2:0] MODE_ONESHOT = 3'b011;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_PERIOD = 1;
  localparam int ADDR_CMP_BASE = 2;
  localparam int PRESCALE_W = 7;
endpackage

// File: rtl/ost_regs.sv
module ost_regs
  import ost_pkg::*;
#(
  parameter int CW = 16,
  parameter int NCH = 3,
  parameter int AW = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [CW-1:0]           wdata,
  output logic [CW-1:0]           rdata,
  output logic                    en,
  output logic [2:0]              csel,
  output logic [2:0]              mode,
  output logic [CW-1:0]           period,
  output logic [NCH-1:0][CW-1:0]  cmp,
  output logic                    sw_pulse
);
  logic [CW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (int'(addr) == ADDR_CTRL) rd_mux[6:0] = {mode, csel, en};
    if (int'(addr) == ADDR_PERIOD) rd_mux = period;
    for (int i = 0; i < NCH; i++)
      if (int'(addr) == ADDR_CMP_BASE + i) rd_mux = cmp[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0;
      csel <= '0;
      mode <= '0;
      period <= '0;
      cmp <= '0;
      sw_pulse <= 1'b0;
      rdata <= '0;
    end else begin
      sw_pulse <= 1'b0;
      rdata <= rd_mux;
      if (wr) begin
        if (int'(addr) == ADDR_CTRL) begin
          en <= wdata[0];
          csel <= wdata[3:1];
          mode <= wdata[6:4];
          sw_pulse <= wdata[7];
        end
        if (int'(addr) == ADDR_PERIOD) period <= wdata;
        for (int i = 0; i < NCH; i++)
          if (int'(addr) == ADDR_CMP_BASE + i) cmp[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/ost_sync.sv
module ost_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
endmodule

// File: rtl/ost_core.sv
module ost_core
  import ost_pkg::*;
#(
  parameter int CW = 16,
  parameter int NCH = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic [2:0]              csel,
  input  logic                    trig,
  input  logic [CW-1:0]           period,
  input  logic [NCH-1:0][CW-1:0]  cmp,
  output logic [CW-1:0]           cnt_q,
  output logic                    busy_q,
  output logic                    irq_prd_q,
  output logic [CW-1:0]           cnt_n,
  output logic                    busy_n,
  output logic                    adv_n,
  output logic [CW-1:0]           prd_n,
  output logic [NCH-1:0][CW-1:0]  cmpb_n
);
  localparam logic [CW-1:0] PARK = '1;

  logic [PRESCALE_W-1:0] pre_q, pre_n, mask;
  logic [CW-1:0] prd_q;
  logic [NCH-1:0][CW-1:0] cmpb_q;
  logic tick;

  assign mask = ~({PRESCALE_W{1'b1}} << csel);
  assign tick = (pre_q == mask);

  always_comb begin
    cnt_n = cnt_q;
    busy_n = busy_q;
    prd_n = prd_q;
    cmpb_n = cmpb_q;
    adv_n = 1'b0;
    pre_n = pre_q + 1'b1;
    if (!run) begin
      busy_n = 1'b0;
      cnt_n = PARK;
      pre_n = '0;
    end else if (!busy_q) begin
      pre_n = '0;
      if (trig) begin
        busy_n = 1'b1;
        cnt_n = '0;
        adv_n = 1'b1;
        prd_n = period;
        cmpb_n = cmp;
      end
    end else if (tick) begin
      pre_n = '0;
      if (cnt_q == prd_q) begin
        busy_n = 1'b0;
        cnt_n = PARK;
      end else begin
        cnt_n = cnt_q + 1'b1;
        adv_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= PARK;
      busy_q <= 1'b0;
      pre_q <= '0;
      prd_q <= '0;
      cmpb_q <= '0;
      irq_prd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      busy_q <= busy_n;
      pre_q <= pre_n;
      prd_q <= prd_n;
      cmpb_q <= cmpb_n;
      irq_prd_q <= adv_n && (cnt_n == prd_n);
    end
  end
endmodule

// File: rtl/ost_chan.sv
module ost_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy_n,
  input  logic          adv_n,
  input  logic [CW-1:0] cnt_n,
  input  logic [CW-1:0] cmp_n,
  input  logic [CW-1:0] prd_n,
  output logic          pulse_q,
  output logic          irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      pulse_q <= busy_n && (cnt_n >= cmp_n) && (cnt_n <= prd_n);
      irq_q <= adv_n && (cnt_n == cmp_n);
    end
  end
endmodule

// File: rtl/one_shot_timer.sv
module one_shot_timer
  import ost_pkg::*;
#(
  parameter int CW = 16,
  parameter int NCH = 3,
  parameter int AW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [CW-1:0]  reg_wdata,
  output logic [CW-1:0]  reg_rdata,
  input  logic           ext_trig,
  output logic [NCH-1:0] pulse_out,
  output logic [NCH:0]   irq_out,
  output logic [CW-1:0]  count_out
);
  logic ctrl_en, sw_pulse, ext_rise, core_busy;
  logic [2:0] csel, mode;
  logic [CW-1:0] period, cnt_n, prd_n;
  logic [NCH-1:0][CW-1:0] cmp, cmpb_n;
  logic busy_n, adv_n;

  ost_regs #(.CW(CW), .NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .en(ctrl_en), .csel(csel), .mode(mode),
    .period(period), .cmp(cmp), .sw_pulse(sw_pulse)
  );

  ost_sync u_sync (
    .clk(clk), .rst(rst), .async_in(ext_trig), .rise(ext_rise)
  );

  ost_core #(.CW(CW), .NCH(NCH)) u_core (
    .clk(clk), .rst(rst), .run(ctrl_en && (mode == MODE_ONESHOT)),
    .csel(csel), .trig(sw_pulse | ext_rise), .period(period), .cmp(cmp),
    .cnt_q(count_out), .busy_q(core_busy), .irq_prd_q(irq_out[0]),
    .cnt_n(cnt_n), .busy_n(busy_n), .adv_n(adv_n), .prd_n(prd_n),
    .cmpb_n(cmpb_n)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    ost_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst(rst), .busy_n(busy_n), .adv_n(adv_n), .cnt_n(cnt_n),
      .cmp_n(cmpb_n[k]), .prd_n(prd_n), .pulse_q(pulse_out[k]),
      .irq_q(irq_out[k+1])
    );
  end
endmodule

// File: rtl/one_shot_timer_chk.sv
module one_shot_timer_chk #(
  parameter int CW = 16,
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic           busy,
  input logic [CW-1:0]  count_out,
  input logic [NCH-1:0] pulse_out,
  input logic [NCH:0]   irq_out
);
  localparam logic [CW-1:0] PARK = '1;

  // R3 / R6: a waiting counter is parked at all-ones
  p_idle_parked_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> count_out == PARK);

  // R5: while running, the counter only holds or steps by one
  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (count_out == $past(count_out) ||
                               count_out == $past(count_out) + 1'b1));

  // R10: disabling clears outputs and parks the counter
  p_disable_clears_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pulse_out == '0 && count_out == PARK));

  // R6: no channel is active outside a running pulse
  p_pulse_in_run_r6: assert property (@(posedge clk) disable iff (rst)
    (pulse_out != '0) |-> busy);

  // R8: the period interrupt is a single-cycle strobe
  p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
    irq_out[0] |=> !irq_out[0]);

  // R8: interrupts only fire during a running pulse
  p_irq_in_run_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_out != '0) |-> busy);
endmodule

bind one_shot_timer one_shot_timer_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .en(ctrl_en), .busy(core_busy),
  .count_out(count_out), .pulse_out(pulse_out), .irq_out(irq_out)
);

// File: tb/tb_one_shot_timer.sv
module tb_one_shot_timer;
  localparam int CW = 8;
  localparam int NCH = 3;
  localparam int AW = 3;
  localparam int PARK = 255;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic ext_trig = 1'b0;
  logic [NCH-1:0] pulse_out;
  logic [NCH:0] irq_out;
  logic [CW-1:0] count_out;

  int n_chk = 0;
  int n_bad = 0;

  int on_first[NCH];
  int on_cnt[NCH];
  int irq_first[NCH+1];
  int irq_cnt[NCH+1];
  int end_at;
  int start_cnt;

  int mon_p0 = 0;
  int mon_starts = 0;
  int mon_prev = PARK;

  always #2 clk = ~clk;

  one_shot_timer #(.CW(CW), .NCH(NCH), .AW(AW)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_trig(ext_trig),
    .pulse_out(pulse_out), .irq_out(irq_out), .count_out(count_out)
  );

  always @(negedge clk) begin
    if (pulse_out[0]) mon_p0++;
    if (count_out == 0 && mon_prev != 0) mon_starts++;
    mon_prev = int'(count_out);
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ctl(int en, int sel, int mode, int sw);
    return (sw << 7) | (mode << 4) | (sel << 1) | en;
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_addr = AW'(a);
    reg_wdata = CW'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    reg_addr = AW'(a);
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  task automatic observe(int len);
    for (int k = 0; k < NCH; k++) begin on_first[k] = -1; on_cnt[k] = 0; end
    for (int k = 0; k <= NCH; k++) begin irq_first[k] = -1; irq_cnt[k] = 0; end
    end_at = -1;
    start_cnt = -1;
    for (int i = 0; i < len; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 1) start_cnt = int'(count_out);
      if (i >= 2 && end_at < 0 && count_out == CW'(PARK)) end_at = i;
      for (int k = 0; k < NCH; k++)
        if (pulse_out[k]) begin
          if (on_first[k] < 0) on_first[k] = i;
          on_cnt[k]++;
        end
      for (int k = 0; k <= NCH; k++)
        if (irq_out[k]) begin
          if (irq_first[k] < 0) irq_first[k] = i;
          irq_cnt[k]++;
        end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, d, p_before;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 count", int'(count_out), PARK);
    check("R1 pulse", int'(pulse_out), 0);
    check("R1 irq", int'(irq_out), 0);
    rd(0, v); check("R1 ctrl reg", v, 0);
    rd(1, v); check("R1 period reg", v, 0);

    // R2 register map and readback; R3 trigger ignored while disabled
    wr(1, 8'hA5);
    wr(3, 8'h3C);
    wr(0, ctl(0, 5, 3, 1));
    observe(6);
    check("R3 disabled trigger ignored", end_at, 2);
    check("R3 disabled no pulse", on_cnt[0] + on_cnt[1] + on_cnt[2], 0);
    rd(0, v); check("R2 ctrl readback, strobe reads 0", v, 58);
    rd(1, v); check("R2 period readback", v, 165);
    rd(3, v); check("R2 cmp2 readback", v, 60);
    rd(5, v); check("R2 unmapped reads 0", v, 0);

    // R12 foreign mode ignores triggers
    wr(1, 3); wr(2, 0);
    wr(0, ctl(1, 0, 2, 1));
    observe(8);
    check("R12 foreign mode count", end_at, 2);
    check("R12 foreign mode no pulse", on_cnt[0], 0);

    // R3 R5 R6 R8 R11 sweep
    for (int sel = 0; sel < 3; sel++)
      for (int c0 = 0; c0 < 8; c0++)
        for (int c1 = 0; c1 < 9; c1++) begin
          int dv;
          dv = 1 << sel;
          wr(1, c0); wr(2, c1); wr(3, c0); wr(4, c0 + 1);
          wr(0, ctl(1, sel, 3, 1));
          observe(1 + (c0 + 1) * dv + 3);
          check("R3 sw trigger starts at 0", start_cnt, 0);
          check("R5 ch1 delay", on_first[0], (c1 <= c0) ? 1 + c1 * dv : -1);
          check("R5 ch1 width", on_cnt[0], (c1 <= c0) ? (c0 - c1 + 1) * dv : 0);
          check("R5 ch2 delay", on_first[1], 1 + c0 * dv);
          check("R5 ch2 width", on_cnt[1], dv);
          check("R11 ch3 width", on_cnt[2], 0);
          check("R11 ch3 irq", irq_cnt[3], 0);
          check("R8 irq0 position", irq_first[0], 1 + c0 * dv);
          check("R8 irq0 count", irq_cnt[0], 1);
          check("R8 irq1 count", irq_cnt[1], (c1 <= c0) ? 1 : 0);
          check("R8 irq1 position", irq_first[1], (c1 <= c0) ? 1 + c1 * dv : -1);
          check("R6 return to park", end_at, 1 + (c0 + 1) * dv);
        end

    // R4 external trigger latency
    wr(1, 3); wr(2, 1);
    wr(0, ctl(1, 0, 3, 0));
    ext_trig = 1'b1;
    @(negedge clk); check("R4 after 1 edge", int'(count_out), PARK);
    @(negedge clk); check("R4 after 2 edges", int'(count_out), PARK);
    @(negedge clk); check("R4 after 3 edges", int'(count_out), 0);
    repeat (10) @(negedge clk);
    ext_trig = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 parked after external pulse", int'(count_out), PARK);

    // R7 retrigger from both sources during a pulse
    wr(1, 12); wr(2, 2);
    mon_p0 = 0; mon_starts = 0;
    wr(0, ctl(1, 0, 3, 1));
    repeat (3) @(negedge clk);
    wr(0, ctl(1, 0, 3, 1));
    ext_trig = 1'b1;
    repeat (25) @(negedge clk);
    ext_trig = 1'b0;
    check("R7 single start", mon_starts, 1);
    check("R7 width unchanged", mon_p0, 11);
    check("R7 parked afterwards", int'(count_out), PARK);
    repeat (5) @(negedge clk);

    // R9 compare buffers captured at trigger
    wr(1, 6); wr(2, 2);
    mon_p0 = 0; mon_starts = 0;
    wr(0, ctl(1, 0, 3, 1));
    wr(2, 5); wr(1, 7);
    repeat (15) @(negedge clk);
    check("R9 current pulse keeps old compares", mon_p0, 5);
    p_before = mon_p0;
    wr(0, ctl(1, 0, 3, 1));
    repeat (15) @(negedge clk);
    check("R9 next pulse uses new compares", mon_p0 - p_before, 3);
    check("R9 two starts", mon_starts, 2);

    // R10 disable mid-pulse
    wr(1, 20); wr(2, 1);
    wr(0, ctl(1, 0, 3, 1));
    repeat (4) @(negedge clk);
    check("R10 pulse running before disable", int'(pulse_out[0]), 1);
    wr(0, ctl(0, 0, 3, 0));
    @(negedge clk);
    check("R10 outputs low", int'(pulse_out), 0);
    check("R10 counter parked", int'(count_out), PARK);
    wr(0, ctl(1, 0, 3, 0));
    repeat (5) @(negedge clk);
    check("R10 no pending trigger", int'(count_out), PARK);
    check("R10 no pulse after re-enable", int'(pulse_out), 0);
    d = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad + d);
    $finish;
  end
endmodule